// File: doc/BRIEF.md
# Mode-Selectable Parallel RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB display: an active-low horizontal sync, an active-low vertical sync, a data-enable strobe and the current pixel column and row. The display geometry is not fixed. A 3-bit resolution code, normally driven from a configuration register, selects one of five built-in timing sets, each with its own active size, front porch, sync width and back porch on both axes. A single pixel clock enable advances all counters, so the block can sit in a faster system clock domain and step once per pixel.

The block reads the resolution code only at frame boundaries, so a change never produces a torn frame. One of the codes is an alias that reuses another mode's timing. Two codes have no timing; the block flags them and keeps the raster idle. A standby input parks the raster at the origin and forces every output inactive. While the raster is idle, whether from standby or from an unsupported code, the code is re-read on every clock. A pixel source downstream qualifies its data with `de` and addresses it with `pix_x`/`pix_y`. No data stream enters or leaves the block, so it has no valid/ready interface and no back-pressure.

Top module: `lcd_timing_gen`

## Requirements
- R1: `pix_x`/`pix_y` give the raster position. They count from 0. The horizontal count advances by one on each clock where `pix_ce` is high and the raster runs, and it wraps to 0 after the line's last back-porch pixel. The row advances when the horizontal count wraps. Without `pix_ce` the position holds.
- R2: `de` is high exactly when the raster runs with `pix_x` below the active width and `pix_y` below the active height.
- R3: Each line is active width + front porch + sync + back porch pixels long. `hsync_n` is low for the sync pixels, starting at column active width + front porch.
- R4: Each frame is active height + front porch + sync + back porch lines long. `vsync_n` is low for the whole of each sync line, starting at row active height + front porch.
- R5: Mode codes select these timings: 7 → 800x480, horizontal 40/1/216, vertical 10/1/35; 6 → 640x480, 24/1/136, 18/1/27; 5 → 480x272, 2/1/43, 2/1/12; 4 → 480x640, 2/1/43, 4/1/8; 0 → 400x240, 20/1/108, 2/1/20. The porches are listed as front/sync/back. Both active dimensions are divided by parameter `ACT_DIV`.
- R6: Code 1 uses exactly the timing of code 5.
- R7: Codes 2 and 3 are unsupported. While one of them is in effect, `mode_bad` is high, the counters sit at 0, and `hsync_n`=1, `vsync_n`=1, `de`=0.
- R8: While the raster runs, a new code takes effect only on the clock that ends the last pixel of the frame's last line, so the next frame starts in the new mode.
- R9: While `standby` is high, the outputs are inactive in the same cycle: syncs high, `de` low, position 0. The counters clear on the next clock, and the code is reloaded on every clock. After release, the raster starts from (0,0).
- R10: Reset (`rst_n` low, synchronous) clears the position and selects mode `RST_CODE` (default 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_ce | input | 1 | Pixel step enable |
| standby | input | 1 | Park raster, outputs inactive |
| res_code | input | 3 | Requested resolution code |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Active-region data enable |
| pix_x | output | H_W | Raster column |
| pix_y | output | V_W | Raster row |
| mode_bad | output | 1 | Code in effect is unsupported |

## Verification
The bench builds the block with `ACT_DIV` = 16, which shrinks every active area while keeping each porch and sync value at full size. Full frames of all five modes and the alias then fit in a few thousand to about twenty-three thousand cycles. This brings measured frame lengths for every code, mid-frame code changes that must wait for the frame end, and many random mode switches, standby pulses and enable gaps within reach. Counter widths stay at their defaults, so the wide porch comparisons are still exercised.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  localparam int TW = 12;

  typedef logic [2:0] res_code_t;

  // Raw geometry of one mode
  typedef struct packed {
    logic          ok;
    logic [TW-1:0] h_act;
    logic [TW-1:0] h_fp;
    logic [TW-1:0] h_sw;
    logic [TW-1:0] h_bp;
    logic [TW-1:0] v_act;
    logic [TW-1:0] v_fp;
    logic [TW-1:0] v_sw;
    logic [TW-1:0] v_bp;
  } lcdt_geom_t;

  // Precomputed comparison points held in the mode register
  typedef struct packed {
    logic          ok;
    logic [TW-1:0] h_act;
    logic [TW-1:0] h_ss;
    logic [TW-1:0] h_se;
    logic [TW-1:0] h_last;
    logic [TW-1:0] v_act;
    logic [TW-1:0] v_ss;
    logic [TW-1:0] v_se;
    logic [TW-1:0] v_last;
  } lcdt_bnd_t;

  function automatic lcdt_geom_t lcdt_geom(input res_code_t code, input int unsigned div);
    lcdt_geom_t  g;
    int unsigned ha;
    int unsigned va;
    g    = '0;
    g.ok = 1'b1;
    ha   = 0;
    va   = 0;
    case (code)
      3'd7: begin
        ha = 800; va = 480;
        g.h_fp = 12'd40; g.h_bp = 12'd216; g.v_fp = 12'd10; g.v_bp = 12'd35;
      end
      3'd6: begin
        ha = 640; va = 480;
        g.h_fp = 12'd24; g.h_bp = 12'd136; g.v_fp = 12'd18; g.v_bp = 12'd27;
      end
      3'd5, 3'd1: begin
        ha = 480; va = 272;
        g.h_fp = 12'd2; g.h_bp = 12'd43; g.v_fp = 12'd2; g.v_bp = 12'd12;
      end
      3'd4: begin
        ha = 480; va = 640;
        g.h_fp = 12'd2; g.h_bp = 12'd43; g.v_fp = 12'd4; g.v_bp = 12'd8;
      end
      3'd0: begin
        ha = 400; va = 240;
        g.h_fp = 12'd20; g.h_bp = 12'd108; g.v_fp = 12'd2; g.v_bp = 12'd20;
      end
      default: g.ok = 1'b0;
    endcase
    if (g.ok) begin
      g.h_sw = 12'd1;
      g.v_sw = 12'd1;
    end
    g.h_act = TW'(ha / div);
    g.v_act = TW'(va / div);
    return g;
  endfunction

  function automatic lcdt_bnd_t lcdt_bounds(input lcdt_geom_t g);
    lcdt_bnd_t b;
    b.ok     = g.ok;
    b.h_act  = g.h_act;
    b.h_ss   = g.h_act + g.h_fp;
    b.h_se   = b.h_ss + g.h_sw;
    b.h_last = b.h_se + g.h_bp - 12'd1;
    b.v_act  = g.v_act;
    b.v_ss   = g.v_act + g.v_fp;
    b.v_se   = b.v_ss + g.v_sw;
    b.v_last = b.v_se + g.v_bp - 12'd1;
    return b;
  endfunction

endpackage

// File: rtl/lcdt_mode_reg.sv
module lcdt_mode_reg
  import lcdt_pkg::*;
#(
  parameter int unsigned ACT_DIV  = 1,
  parameter logic [2:0]  RST_CODE = 3'd7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  res_code_t code_in,
  output lcdt_bnd_t bnd
);

  localparam lcdt_bnd_t RST_BND = lcdt_bounds(lcdt_geom(RST_CODE, ACT_DIV));

  lcdt_bnd_t nxt_bnd;

  always_comb nxt_bnd = lcdt_bounds(lcdt_geom(code_in, ACT_DIV));

  always_ff @(posedge clk) begin
    if (!rst_n)    bnd <= RST_BND;
    else if (load) bnd <= nxt_bnd;
  end

endmodule

// File: rtl/lcdt_ctr.sv
module lcdt_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  always_comb wrap = step && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (step)     cnt <= wrap ? '0 : cnt + W'(1);
  end

endmodule

// File: rtl/lcdt_raster_out.sv
module lcdt_raster_out #(
  parameter int H_W = 11,
  parameter int V_W = 10
) (
  input  logic           run,
  input  logic [H_W-1:0] h_cnt,
  input  logic [V_W-1:0] v_cnt,
  input  logic [H_W-1:0] h_act,
  input  logic [H_W-1:0] h_ss,
  input  logic [H_W-1:0] h_se,
  input  logic [V_W-1:0] v_act,
  input  logic [V_W-1:0] v_ss,
  input  logic [V_W-1:0] v_se,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic           de,
  output logic [H_W-1:0] pix_x,
  output logic [V_W-1:0] pix_y
);

  logic in_hs, in_vs, in_h, in_v;

  always_comb begin
    in_h    = h_cnt < h_act;
    in_v    = v_cnt < v_act;
    in_hs   = (h_cnt >= h_ss) && (h_cnt < h_se);
    in_vs   = (v_cnt >= v_ss) && (v_cnt < v_se);
    de      = run && in_h && in_v;
    hsync_n = !(run && in_hs);
    vsync_n = !(run && in_vs);
    pix_x   = run ? h_cnt : '0;
    pix_y   = run ? v_cnt : '0;
  end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int unsigned ACT_DIV  = 1,
  parameter int          H_W      = 11,
  parameter int          V_W      = 10,
  parameter logic [2:0]  RST_CODE = 3'd7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_ce,
  input  logic           standby,
  input  logic [2:0]     res_code,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic           de,
  output logic [H_W-1:0] pix_x,
  output logic [V_W-1:0] pix_y,
  output logic           mode_bad
);

  localparam int unsigned DIV_SAFE = (ACT_DIV == 0) ? 1 : ACT_DIV;

  lcdt_bnd_t      bnd;
  logic           run, adv, load;
  logic           h_wrap, v_wrap;
  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;

  always_comb begin
    run      = !standby && bnd.ok;
    adv      = run && pix_ce;
    load     = !run || v_wrap;
    mode_bad = !bnd.ok;
  end

  lcdt_mode_reg #(
    .ACT_DIV  (DIV_SAFE),
    .RST_CODE (RST_CODE)
  ) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .code_in (res_code),
    .bnd     (bnd)
  );

  lcdt_ctr #(.W(H_W)) u_hctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run),
    .step  (adv),
    .last  (H_W'(bnd.h_last)),
    .cnt   (h_cnt),
    .wrap  (h_wrap)
  );

  lcdt_ctr #(.W(V_W)) u_vctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run),
    .step  (h_wrap),
    .last  (V_W'(bnd.v_last)),
    .cnt   (v_cnt),
    .wrap  (v_wrap)
  );

  lcdt_raster_out #(.H_W(H_W), .V_W(V_W)) u_out (
    .run     (run),
    .h_cnt   (h_cnt),
    .v_cnt   (v_cnt),
    .h_act   (H_W'(bnd.h_act)),
    .h_ss    (H_W'(bnd.h_ss)),
    .h_se    (H_W'(bnd.h_se)),
    .v_act   (V_W'(bnd.v_act)),
    .v_ss    (V_W'(bnd.v_ss)),
    .v_se    (V_W'(bnd.v_se)),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .de      (de),
    .pix_x   (pix_x),
    .pix_y   (pix_y)
  );

endmodule

// File: rtl/lcdt_chk.sv
module lcdt_chk #(
  parameter int H_W = 11,
  parameter int V_W = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pix_ce,
  input logic           standby,
  input logic           hsync_n,
  input logic           vsync_n,
  input logic           de,
  input logic [H_W-1:0] pix_x,
  input logic [V_W-1:0] pix_y,
  input logic           mode_bad,
  input logic [H_W-1:0] h_cnt,
  input logic [V_W-1:0] v_cnt
);

  // R1
  hold_without_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ce && !standby && !mode_bad) |=> (standby || ($stable(pix_x) && $stable(pix_y))));

  // R2
  de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync_n && vsync_n));

  // R4
  vsync_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> (pix_x == '0));

  // R7
  bad_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bad |-> (!de && hsync_n && vsync_n && pix_x == '0 && pix_y == '0));

  // R8
  bad_mode_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_bad) |-> (h_cnt == '0 && v_cnt == '0));

  // R9
  standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!de && hsync_n && vsync_n && pix_x == '0 && pix_y == '0));

endmodule

bind lcd_timing_gen lcdt_chk #(.H_W(H_W), .V_W(V_W)) u_lcdt_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_ce   (pix_ce),
  .standby  (standby),
  .hsync_n  (hsync_n),
  .vsync_n  (vsync_n),
  .de       (de),
  .pix_x    (pix_x),
  .pix_y    (pix_y),
  .mode_bad (mode_bad),
  .h_cnt    (h_cnt),
  .v_cnt    (v_cnt)
);

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;

  localparam int DIV = 16;
  localparam int HW  = 11;
  localparam int VW  = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, pix_ce, standby;
  logic [2:0]    res_code;
  logic          hsync_n, vsync_n, de, mode_bad;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;

  int n_chk = 0;
  int n_err = 0;

  lcd_timing_gen #(.ACT_DIV(DIV), .H_W(HW), .V_W(VW)) i_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .standby(standby), .res_code(res_code),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .mode_bad(mode_bad)
  );

  // k: 0 h active, 1 h front, 2 h sync, 3 h back, 4 v active, 5 v front, 6 v sync, 7 v back
  function automatic int tv(int c, int k);
    int t[8];
    case (c)
      7:       t = '{800, 40, 1, 216, 480, 10, 1, 35};
      6:       t = '{640, 24, 1, 136, 480, 18, 1, 27};
      5, 1:    t = '{480, 2, 1, 43, 272, 2, 1, 12};
      4:       t = '{480, 2, 1, 43, 640, 4, 1, 8};
      0:       t = '{400, 20, 1, 108, 240, 2, 1, 20};
      default: t = '{0, 0, 0, 0, 0, 0, 0, 0};
    endcase
    if (k == 0 || k == 4) return t[k] / DIV;
    return t[k];
  endfunction

  function automatic bit legal(int c);
    return (c != 2) && (c != 3);
  endfunction

  function automatic int htot(int c);
    return tv(c, 0) + tv(c, 1) + tv(c, 2) + tv(c, 3);
  endfunction

  function automatic int vtot(int c);
    return tv(c, 4) + tv(c, 5) + tv(c, 6) + tv(c, 7);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference raster built from the requirements
  int mh = 0, mv = 0, mc = 7;
  always @(posedge clk) begin
    if (!rst_n) begin
      mh <= 0; mv <= 0; mc <= 7;
    end else if (standby || !legal(mc)) begin
      mh <= 0; mv <= 0; mc <= int'(res_code);
    end else if (pix_ce) begin
      if (mh == htot(mc) - 1) begin
        mh <= 0;
        if (mv == vtot(mc) - 1) begin
          mv <= 0; mc <= int'(res_code);
        end else mv <= mv + 1;
      end else mh <= mh + 1;
    end
  end

  task automatic cmp();
    bit run;
    int hs, vs;
    run = !standby && legal(mc);
    hs  = tv(mc, 0) + tv(mc, 1);
    vs  = tv(mc, 4) + tv(mc, 5);
    chk("R1", "pix_x", int'(pix_x), run ? mh : 0);
    chk("R1", "pix_y", int'(pix_y), run ? mv : 0);
    chk("R2", "de", int'(de), int'(run && mh < tv(mc, 0) && mv < tv(mc, 4)));
    chk("R3", "hsync_n", int'(hsync_n), int'(!(run && mh >= hs && mh < hs + tv(mc, 2))));
    chk("R4", "vsync_n", int'(vsync_n), int'(!(run && mv >= vs && mv < vs + tv(mc, 6))));
    chk("R7", "mode_bad", int'(mode_bad), int'(!legal(mc)));
  endtask

  task automatic cyc();
    @(negedge clk);
    cmp();
    if (n_err > 40) begin
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Restart in code c through standby; returns cycles until the raster is back at the origin
  task automatic frame_len(int c, int switch_at, int new_code, output int n, output int bad_at);
    standby = 1'b1; res_code = 3'(c); pix_ce = 1'b1;
    cyc();
    cyc();
    // R9: idle while standby
    chk("R9", "standby de", int'(de), 0);
    chk("R9", "standby hsync_n", int'(hsync_n), 1);
    standby = 1'b0;
    n = 0; bad_at = -1;
    for (int i = 1; i < 40000; i++) begin
      cyc();
      if (i == switch_at) res_code = 3'(new_code);
      if (mode_bad && bad_at < 0) bad_at = i;
      if (pix_x == '0 && pix_y == '0 && n == 0) begin
        n = i;
        if (switch_at < 0) break;
      end
      if (switch_at >= 0 && bad_at >= 0) break;
    end
  endtask

  initial begin
    #1_900_000;
    n_err++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int n, b;
    int codes[6];
    codes = '{7, 6, 5, 4, 0, 1};
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0; standby = 1'b0; pix_ce = 1'b1; res_code = 3'd2;
    cyc();
    // R10: reset state, mode 7 active at origin
    chk("R10", "reset pix_x", int'(pix_x), 0);
    chk("R10", "reset de", int'(de), 1);
    chk("R10", "reset mode_bad", int'(mode_bad), 0);
    cyc();
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) cyc();
    // R8: code 2 requested right after reset is not yet in effect
    chk("R8", "mode_bad mid-frame", int'(mode_bad), 0);

    // R5 / R6: frame length for every code
    foreach (codes[k]) begin
      frame_len(codes[k], -1, 0, n, b);
      chk(codes[k] == 1 ? "R6" : "R5", $sformatf("frame cycles code %0d", codes[k]),
          n, htot(codes[k]) * vtot(codes[k]));
    end

    // R8: switch to unsupported code mid-frame, takes effect at the frame end
    frame_len(5, 37, 3, n, b);
    chk("R8", "mode_bad rise cycle", b, htot(5) * vtot(5));
    // R7: idle while unsupported
    for (int i = 0; i < 5; i++) cyc();
    chk("R7", "bad mode de", int'(de), 0);
    chk("R7", "bad mode vsync_n", int'(vsync_n), 1);
    chk("R7", "bad mode pix_y", int'(pix_y), 0);
    res_code = 3'd4;
    cyc();
    cyc();
    chk("R7", "recovery mode_bad", int'(mode_bad), 0);

    // R1: no advance without pix_ce
    pix_ce = 1'b0;
    for (int i = 0; i < 4; i++) cyc();
    chk("R1", "hold x", int'(pix_x), 1);

    // Random mix of enables, code changes and standby pulses
    for (int i = 0; i < 40000; i++) begin
      cyc();
      pix_ce = ($urandom % 10) < 7;
      if ($urandom % 600 == 0) res_code = 3'($urandom % 8);
      if ($urandom % 1500 == 0) standby = 1'b1;
      else if (standby && ($urandom % 4 == 0)) standby = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule